// File: doc/BRIEF.md
# Bottleneck Waiting-Cycle Table

This block keeps a small associative table of contended code regions ("bottlenecks"). Small cores report, through a single event port, when a thread starts waiting on a bottleneck and when it stops, each event tagged with the bottleneck's identifier. Every entry holds the identifier, the number of threads currently waiting on it, and a waiting-cycle score that grows each cycle by that waiter count. The score is therefore a measure of how much thread time the bottleneck is costing.

Two decisions come out of the table. When an entry's score rises above a programmable threshold, a one-cycle update names the bottleneck and the large core that should run it, so the per-core index tables can mark it for acceleration. When aging later halves the score to the threshold or below, a matching update clears the mark. Separately, when the bottleneck that a small core is currently executing becomes the entry with the highest score, a one-cycle preemption request goes to that small core. Updates leave through a two-state notifier: `NTF_WATCH` scans for an entry whose mark disagrees with its score and, on finding one, takes the transition to `NTF_SEND`. `NTF_SEND` drives the update for one cycle, flips the mark and always returns to `NTF_WATCH`.

Top module: `bneck_wait_table`

## Requirements
- R1: A begin event (`ev_begin`=1) whose identifier is in the table adds one waiter to that entry. On a miss it claims the lowest-numbered empty entry, which then holds one waiter and a score of zero.
- R2: An end event (`ev_begin`=0) removes one waiter from the matching entry. The count stops at zero, and an end event for an identifier not in the table changes nothing.
- R3: On every clock edge that is not an aging edge, each entry's score grows by its waiter count as it stood before that edge. Two waiters add 2 per cycle and zero waiters add nothing.
- R4: When an unmarked entry's score exceeds `thr_level`, the notifier raises `upd_valid` for exactly one cycle with `upd_set`=1, the entry's identifier and the `acc_core` value it captured, and the entry becomes marked. Only one update is sent at a time, lowest entry first.
- R5: Every 2^AGE_LOG cycles after reset, all scores are shifted right by one bit. A marked entry whose score is then at or below `thr_level` receives an update with `upd_set`=0 and becomes unmarked.
- R6: Scores saturate at their all-ones value and never wrap.
- R7: A begin event that misses a full table replaces the valid entry with the smallest score, taking the lowest index on a tie. Every other entry keeps its score.
- R8: When `run_valid` is high and `run_id` matches the entry holding the largest non-zero score (lowest index on a tie), `preempt_valid` pulses for one cycle, with `preempt_core` equal to `run_core`. It does not pulse again until that condition has dropped and risen again.
- R9: While `rst_n` is low, `upd_valid` and `preempt_valid` are low, the table is empty and the aging counter restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Wait event present this cycle |
| ev_begin | input | 1 | 1 = a thread begins waiting, 0 = it stops |
| ev_id | input | ID_W | Bottleneck identifier of the event |
| thr_level | input | TWC_W | Programmable acceleration threshold |
| acc_core | input | LCORE_W | Large core named in set/clear updates |
| run_valid | input | 1 | A bottleneck is running on a small core |
| run_id | input | ID_W | Identifier of that running bottleneck |
| run_core | input | SCORE_W | Small core running it |
| upd_valid | output | 1 | Mark update valid (one cycle) |
| upd_set | output | 1 | 1 = mark for acceleration, 0 = clear mark |
| upd_id | output | ID_W | Bottleneck named in the update |
| upd_core | output | LCORE_W | Target large core of the update |
| preempt_valid | output | 1 | Preemption request (one cycle) |
| preempt_core | output | SCORE_W | Small core to be preempted |

## Verification
Saturation and periodic halving both act on the same score counter, so the order in which they take effect decides when a clear is sent. The bench drives one entry well past saturation, keeps it marked across several aging edges, and judges the result by the cycle of its clear update. A saturated score needs four halvings to fall under the threshold, while a wrapped one would clear an aging period earlier or drop its mark during the hold. The same run places a second entry so that its clear falls on the first aging edge, which checks that halving and the notifier's scan work together.

// File: rtl/bnw_pkg.sv
package bnw_pkg;

    // notifier states: scan for a mark/score mismatch, then emit one update
    typedef enum logic {
        NTF_WATCH = 1'b0,
        NTF_SEND  = 1'b1
    } ntf_state_e;

endpackage

// File: rtl/bnw_entry.sv
module bnw_entry #(
    parameter int ID_W  = 8,
    parameter int CNT_W = 6,
    parameter int TWC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             inc,
    input  logic             dec,
    input  logic             age,
    input  logic             mark_set,
    input  logic             mark_clr,
    input  logic [ID_W-1:0]  new_id,
    output logic             vld,
    output logic [ID_W-1:0]  id,
    output logic [TWC_W-1:0] twc,
    output logic             mark
);

    localparam logic [CNT_W-1:0] W_MAX   = '1;
    localparam logic [TWC_W-1:0] TWC_TOP = '1;

    logic [CNT_W-1:0] waiters;
    logic [TWC_W:0]   sum;

    // one bit wider than the score so that overflow is visible
    assign sum = {1'b0, twc} + {{(TWC_W + 1 - CNT_W){1'b0}}, waiters};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld     <= 1'b0;
            id      <= '0;
            waiters <= '0;
            twc     <= '0;
            mark    <= 1'b0;
        end else if (alloc) begin
            vld     <= 1'b1;
            id      <= new_id;
            waiters <= CNT_W'(1);
            twc     <= '0;
            mark    <= 1'b0;
        end else begin
            if (inc && waiters != W_MAX)
                waiters <= waiters + CNT_W'(1);
            else if (dec && waiters != '0)
                waiters <= waiters - CNT_W'(1);

            if (age)
                twc <= twc >> 1;
            else if (sum[TWC_W])
                twc <= TWC_TOP;
            else
                twc <= sum[TWC_W-1:0];

            if (mark_set)
                mark <= 1'b1;
            else if (mark_clr)
                mark <= 1'b0;
        end
    end

endmodule

// File: rtl/bnw_pick.sv
module bnw_pick #(
    parameter int N     = 32,
    parameter int IDX_W = 5,
    parameter int TWC_W = 32
) (
    input  logic [N-1:0]     vld,
    input  logic [TWC_W-1:0] twc [N],
    output logic [IDX_W-1:0] min_idx,
    output logic [IDX_W-1:0] max_idx,
    output logic [TWC_W-1:0] max_twc,
    output logic [IDX_W-1:0] free_idx,
    output logic             free_any
);

    logic [TWC_W-1:0] min_v;

    // smallest valid score; strict compare keeps the lowest index on ties
    always_comb begin
        min_v   = '1;
        min_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && twc[i] < min_v) begin
                min_v   = twc[i];
                min_idx = IDX_W'(i);
            end
        end
    end

    // largest valid score, lowest index on ties
    always_comb begin
        max_twc = '0;
        max_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && twc[i] > max_twc) begin
                max_twc = twc[i];
                max_idx = IDX_W'(i);
            end
        end
    end

    // lowest empty slot
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!vld[i] && !free_any) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/bneck_wait_table.sv
module bneck_wait_table
    import bnw_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int ID_W    = 8,
    parameter int CNT_W   = 6,
    parameter int TWC_W   = 32,
    parameter int AGE_LOG = 16,
    parameter int SCORE_W = 4,
    parameter int LCORE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic               ev_begin,
    input  logic [ID_W-1:0]    ev_id,
    input  logic [TWC_W-1:0]   thr_level,
    input  logic [LCORE_W-1:0] acc_core,
    input  logic               run_valid,
    input  logic [ID_W-1:0]    run_id,
    input  logic [SCORE_W-1:0] run_core,
    output logic               upd_valid,
    output logic               upd_set,
    output logic [ID_W-1:0]    upd_id,
    output logic [LCORE_W-1:0] upd_core,
    output logic               preempt_valid,
    output logic [SCORE_W-1:0] preempt_core
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] e_vld, e_mark, hit_v, need_v;
    logic [ENTRIES-1:0] alloc_v, inc_v, dec_v, mset_v, mclr_v;
    logic [ID_W-1:0]    e_id  [ENTRIES];
    logic [TWC_W-1:0]   e_twc [ENTRIES];

    logic [IDX_W-1:0]   min_idx, max_idx, free_idx, alloc_idx, need_idx;
    logic [TWC_W-1:0]   max_twc;
    logic               free_any, hit_any, need_any;

    logic [AGE_LOG-1:0] age_cnt;
    logic               age_tick;

    ntf_state_e         state_q, state_d;
    logic [IDX_W-1:0]   sel_idx_q;
    logic [ID_W-1:0]    sel_id_q;
    logic               sel_set_q;
    logic [LCORE_W-1:0] sel_core_q;

    logic               top_hit, top_hit_q, preempt_q;
    logic [SCORE_W-1:0] pcore_q;

    // ---------------- aging period ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_cnt <= '0;
        else        age_cnt <= age_cnt + AGE_LOG'(1);
    end
    assign age_tick = &age_cnt;

    // ---------------- entry array ----------------
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign hit_v[g]   = e_vld[g] && (e_id[g] == ev_id);
        assign need_v[g]  = e_vld[g] && (e_mark[g] ? (e_twc[g] <= thr_level)
                                                   : (e_twc[g] >  thr_level));
        assign alloc_v[g] = ev_valid && ev_begin && !hit_any && (alloc_idx == IDX_W'(g));
        assign inc_v[g]   = ev_valid &&  ev_begin && hit_v[g];
        assign dec_v[g]   = ev_valid && !ev_begin && hit_v[g];
        assign mset_v[g]  = (state_q == NTF_SEND) &&  sel_set_q && (sel_idx_q == IDX_W'(g))
                            && e_vld[g] && (e_id[g] == sel_id_q);
        assign mclr_v[g]  = (state_q == NTF_SEND) && !sel_set_q && (sel_idx_q == IDX_W'(g))
                            && e_vld[g] && (e_id[g] == sel_id_q);

        bnw_entry #(
            .ID_W  (ID_W),
            .CNT_W (CNT_W),
            .TWC_W (TWC_W)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (alloc_v[g]),
            .inc      (inc_v[g]),
            .dec      (dec_v[g]),
            .age      (age_tick),
            .mark_set (mset_v[g]),
            .mark_clr (mclr_v[g]),
            .new_id   (ev_id),
            .vld      (e_vld[g]),
            .id       (e_id[g]),
            .twc      (e_twc[g]),
            .mark     (e_mark[g])
        );
    end

    bnw_pick #(
        .N     (ENTRIES),
        .IDX_W (IDX_W),
        .TWC_W (TWC_W)
    ) u_pick (
        .vld      (e_vld),
        .twc      (e_twc),
        .min_idx  (min_idx),
        .max_idx  (max_idx),
        .max_twc  (max_twc),
        .free_idx (free_idx),
        .free_any (free_any)
    );

    assign hit_any   = |hit_v;
    assign alloc_idx = free_any ? free_idx : min_idx;

    // lowest entry whose mark disagrees with its score
    always_comb begin
        need_any = 1'b0;
        need_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (need_v[i] && !need_any) begin
                need_any = 1'b1;
                need_idx = IDX_W'(i);
            end
        end
    end

    // ---------------- notifier FSM ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NTF_WATCH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NTF_WATCH: state_d = need_any ? NTF_SEND : NTF_WATCH;
            NTF_SEND:  state_d = NTF_WATCH;
            default:   state_d = NTF_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_idx_q  <= '0;
            sel_id_q   <= '0;
            sel_set_q  <= 1'b0;
            sel_core_q <= '0;
        end else if (state_q == NTF_WATCH && need_any) begin
            sel_idx_q  <= need_idx;
            sel_id_q   <= e_id[need_idx];
            sel_set_q  <= !e_mark[need_idx];
            sel_core_q <= acc_core;
        end
    end

    always_comb begin
        upd_valid = (state_q == NTF_SEND);
        upd_set   = sel_set_q;
        upd_id    = sel_id_q;
        upd_core  = sel_core_q;
    end

    // ---------------- preemption ----------------
    assign top_hit = run_valid && (max_twc != '0) && (e_id[max_idx] == run_id);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_hit_q <= 1'b0;
            preempt_q <= 1'b0;
            pcore_q   <= '0;
        end else begin
            top_hit_q <= top_hit;
            preempt_q <= top_hit && !top_hit_q;
            pcore_q   <= run_core;
        end
    end

    assign preempt_valid = preempt_q;
    assign preempt_core  = pcore_q;

endmodule

// File: rtl/bneck_wait_table_chk.sv
module bneck_wait_table_chk #(
    parameter int SCORE_W = 4,
    parameter int LCORE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_valid,
    input logic [LCORE_W-1:0] upd_core,
    input logic [LCORE_W-1:0] acc_core,
    input logic               run_valid,
    input logic [SCORE_W-1:0] run_core,
    input logic               preempt_valid,
    input logic [SCORE_W-1:0] preempt_core
);

    AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid); // R4

    AST_UPD_CORE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> upd_core == $past(acc_core)); // R4

    AST_PREEMPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_valid |=> !preempt_valid); // R8

    AST_PREEMPT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_valid |-> $past(run_valid)); // R8

    AST_PREEMPT_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_valid |-> preempt_core == $past(run_core)); // R8

endmodule

bind bneck_wait_table bneck_wait_table_chk #(
    .SCORE_W (SCORE_W),
    .LCORE_W (LCORE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .upd_valid     (upd_valid),
    .upd_core      (upd_core),
    .acc_core      (acc_core),
    .run_valid     (run_valid),
    .run_core      (run_core),
    .preempt_valid (preempt_valid),
    .preempt_core  (preempt_core)
);

// File: tb/sim_bneck_wait_table.sv
module sim_bneck_wait_table;

    localparam int CLK_PERIOD = 10;
    localparam int ENT = 4;
    localparam int IDW = 8;
    localparam int CW  = 6;
    localparam int TW  = 10;
    localparam int AL  = 10;
    localparam int SW  = 4;
    localparam int LW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic          ev_begin = 1'b0;
    logic [IDW-1:0] ev_id = '0;
    logic [TW-1:0] thr_level = TW'(100);
    logic [LW-1:0] acc_core = LW'(2);
    logic          run_valid = 1'b0;
    logic [IDW-1:0] run_id = '0;
    logic [SW-1:0] run_core = '0;
    logic          upd_valid, upd_set, preempt_valid;
    logic [IDW-1:0] upd_id;
    logic [LW-1:0] upd_core;
    logic [SW-1:0] preempt_core;

    typedef struct packed {
        logic [IDW-1:0] id;
        logic           set;
    } upd_t;

    upd_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   got_n = 0;
    int   got_stamp [16];
    int   pre_n = 0;
    int   pre_core = 0;
    int   c0 = 0;

    bneck_wait_table #(
        .ENTRIES (ENT), .ID_W (IDW), .CNT_W (CW), .TWC_W (TW),
        .AGE_LOG (AL), .SCORE_W (SW), .LCORE_W (LW)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .ev_valid (ev_valid), .ev_begin (ev_begin),
        .ev_id (ev_id), .thr_level (thr_level), .acc_core (acc_core),
        .run_valid (run_valid), .run_id (run_id), .run_core (run_core),
        .upd_valid (upd_valid), .upd_set (upd_set), .upd_id (upd_id),
        .upd_core (upd_core), .preempt_valid (preempt_valid),
        .preempt_core (preempt_core)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop the scoreboard on every update, count preemptions
    always @(negedge clk) begin
        upd_t e;
        if (rst_n && upd_valid) begin
            if (got_n < 16) got_stamp[got_n] = cyc;
            got_n++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected update", int'({upd_id, upd_set}), -1);
            end else begin
                e = exp_q.pop_front();
                chk(upd_id == e.id && upd_set == e.set, "R4 R5 update id/set",
                    int'({upd_id, upd_set}), int'({e.id, e.set}));
                chk(upd_core == acc_core, "R4 update core", int'(upd_core), int'(acc_core));
            end
        end
        if (rst_n && preempt_valid) begin
            pre_n++;
            pre_core = int'(preempt_core);
        end
    end

    task automatic put(input bit b, input int id);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_begin = b;
        ev_id    = IDW'(id);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic expect_upd(input int id, input bit set);
        upd_t e;
        e.id  = IDW'(id);
        e.set = set;
        exp_q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        ev_valid  = 1'b0;
        run_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!upd_valid && !preempt_valid, "R9 outputs quiet in reset",
            int'({upd_valid, preempt_valid}), 0);
        exp_q.delete();
        got_n = 0;
        pre_n = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // ---- phase 1: allocation, weighted accumulation, set update ----
        do_reset();
        thr_level = TW'(100);
        expect_upd(5, 1'b1);
        put(1'b1, 5);                // R1 miss allocates
        c0 = cyc - 1;
        put(1'b1, 5);                // R1 hit adds a waiter
        wait_cyc(80);
        chk(got_n == 1, "R4 one set update", got_n, 1);
        chk(got_stamp[0] - c0 >= 50 && got_stamp[0] - c0 <= 58,
            "R3 two waiters cross threshold 100", got_stamp[0] - c0, 54);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

        // ---- phase 2: halving clears, saturation holds the mark ----
        do_reset();
        expect_upd(5, 1'b1);
        expect_upd(9, 1'b1);
        expect_upd(5, 1'b0);
        expect_upd(9, 1'b0);
        put(1'b1, 5);
        put(1'b1, 5);
        wait_cyc(60);
        put(1'b0, 5);
        put(1'b0, 5);
        put(1'b1, 9);
        put(1'b1, 9);
        put(1'b1, 9);
        wait_cyc(500);               // 3 per cycle saturates the 10-bit score
        put(1'b0, 9);
        put(1'b0, 9);
        put(1'b0, 9);
        while (cyc < 4200) @(negedge clk);
        chk(got_n == 4, "R5 four updates", got_n, 4);
        chk(got_stamp[2] >= 1015 && got_stamp[2] <= 1040,
            "R5 clear after first halving", got_stamp[2], 1025);
        chk(got_stamp[3] >= 4085 && got_stamp[3] <= 4110,
            "R6 saturated score clears on fourth halving", got_stamp[3], 4097);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

        // ---- phase 3: preemption, end-event floor and unknown end ----
        do_reset();
        thr_level = TW'(1000);
        run_valid = 1'b1;
        run_id    = IDW'(9);
        run_core  = SW'(3);
        put(1'b1, 5);
        put(1'b1, 5);
        wait_cyc(20);
        put(1'b1, 9);
        wait_cyc(10);
        chk(pre_n == 0, "R8 no preempt while other entry leads", pre_n, 0);
        put(1'b0, 5);
        put(1'b0, 5);
        put(1'b0, 5);                // R2 extra end must not wrap the count
        put(1'b0, 12);               // R2 end for an absent id is ignored
        put(1'b1, 9);
        put(1'b1, 9);
        wait_cyc(80);
        chk(pre_n == 1, "R8 single preempt when running id takes the lead (R2 floor)",
            pre_n, 1);
        chk(pre_core == 3, "R8 preempt names running core", pre_core, 3);
        chk(got_n == 0, "R4 no update below threshold", got_n, 0);
        run_valid = 1'b0;

        // ---- phase 4: minimum-score victim ----
        do_reset();
        thr_level = TW'(100);
        expect_upd(1, 1'b1);
        put(1'b1, 1); wait_cyc(90); put(1'b0, 1);
        put(1'b1, 2); wait_cyc(50); put(1'b0, 2);
        put(1'b1, 3); wait_cyc(10); put(1'b0, 3);
        put(1'b1, 4); wait_cyc(30); put(1'b0, 4);
        put(1'b1, 7);                // full table: R7 evicts id 3
        put(1'b1, 1);
        c0 = cyc - 1;
        put(1'b0, 7);
        wait_cyc(40);
        chk(got_n == 1, "R7 one update after eviction", got_n, 1);
        chk(got_n >= 1 && got_stamp[0] - c0 <= 25,
            "R7 high-score entry kept its score", got_stamp[0] - c0, 11);
        chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule